// File: doc/BRIEF.md
# Word-Wide One-Time-Programmable Memory Mode Model

This block is a synthesizable behavioural model of a 16-bit word programmable read-only memory. It is meant as a test target for programmer controllers and boot logic. Each clock it decodes an operating mode from five control inputs: an active-low chip select, an active-low output enable, an active-low program strobe, a flag for high programming voltage and a flag for high voltage on the identifier address line. It then drives a registered data word and a drive-enable that stands in for the tri-state pins.

Programming is one-way. A strobe pulse that is long enough ANDs the data inputs into the addressed word, so bits can only go from one to zero. A synchronous erase input, or reset, returns every word to all ones. While the identifier flag is raised in read conditions, fixed manufacturer and device codes replace the array. Address bit 0 selects which code is shown.

A fault-injection input makes odd addresses absorb several qualifying pulses before they take new data. This lets the retry loop of a controller be exercised. The array depth, the minimum pulse width in cycles and the pulse count under fault are parameters.

Top module: `otp_word_mem`

## Requirements
- R1: With chip select low, output enable low, strobe high and both voltage flags low, the word at the address appears on `dout` with `dout_oe` high one clock later.
- R2: With chip select low and output enable high, or with strobe low while the programming flag is low, `dout_oe` and `dout` are 0 one clock later.
- R3: With chip select high, `dout_oe` is 0 one clock later. A strobe pulse in that state, even with the programming flag set, leaves the array unchanged.
- R4: With the programming flag set and chip select low, holding the strobe low for at least `PULSE_MIN` clocks and then raising it commits the data at the rising edge. The outputs stay off while the strobe is low.
- R5: A commit stores the old word ANDed with the data inputs, so zeros never return to ones.
- R6: A strobe low time shorter than `PULSE_MIN` clocks leaves the word unchanged.
- R7: Verify (chip select, output enable and strobe as in R1, with the programming flag set) returns the stored word one clock later.
- R8: In read conditions with the identifier flag set and the programming flag low, address bit 0 = 0 gives 16'h0020 and bit 0 = 1 gives 16'h008C. The upper byte is zero and the array contents are not shown.
- R9: A one-cycle `erase` pulse, and reset, set every word to 16'hFFFF.
- R10: While `flt_en` is high, a word at an odd address (address bit 0 = 1) commits only on every `FLT_PULSES`-th qualifying pulse. Even addresses commit on each pulse.
- R11: After reset, `dout_oe` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also erases the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prg_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| a9_hi | input | 1 | Overvoltage on identifier address line |
| addr | input | AW | Word address |
| din | input | 16 | Data to program |
| erase | input | 1 | Synchronous whole-array erase |
| flt_en | input | 1 | Fault injection: odd addresses need several pulses |
| dout | output | 16 | Registered read data, 0 when not driven |
| dout_oe | output | 1 | Output drive enable |

## Verification
The hardest state to reach is a partly programmed word under fault injection. The pulse counter of that word must be advanced to one below its limit by whole, valid strobe pulses, with a read-back after each pulse showing no change. The bench repeats the full pulse task at one odd address until the last pulse commits, and then writes an even address to show the fault does not spread. The AND rule is reached by programming the same word twice with overlapping data. The short-pulse rule is reached with a pulse exactly one clock under the minimum.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] ID_MAKER  = 16'h0020;
  localparam logic [WORD_W-1:0] ID_DEVICE = 16'h008C;
  localparam logic [WORD_W-1:0] ERASED    = '1;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_INHIBIT,
    M_OFF,
    M_PROGRAM,
    M_READ,
    M_VERIFY,
    M_IDENT
  } otp_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      prg_n,
  input  logic      vpp_hi,
  input  logic      a9_hi,
  output otp_mode_e mode
);
  always_comb begin
    if (ce_n)                 mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    else if (vpp_hi && !prg_n) mode = M_PROGRAM;
    else if (oe_n || !prg_n)  mode = M_OFF;
    else if (vpp_hi)          mode = M_VERIFY;
    else if (a9_hi)           mode = M_IDENT;
    else                      mode = M_READ;
  end
endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int PULSE_MIN = 9500,
  parameter int AW        = 4,
  parameter int DW        = 16,
  localparam int CW       = $clog2(PULSE_MIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          hold_ok,
  input  logic          prg_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  logic [CW-1:0] cnt_q;
  logic          low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      low_q  <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
    end else begin
      low_q <= active;
      if (active) begin
        if (cnt_q != CW'(PULSE_MIN)) cnt_q <= cnt_q + 1'b1;
        c_addr <= addr;
        c_data <= din;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign commit = low_q && !active && prg_n && hold_ok && (cnt_q == CW'(PULSE_MIN));
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int FLT_PULSES = 3,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flt_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              do_wr;

  generate
    if (FLT_PULSES > 1) begin : g_fault
      localparam int HW = $clog2(FLT_PULSES);
      logic [HW-1:0] hits [DEPTH];
      logic          sel;
      logic          last;
      assign sel   = flt_en && wr_addr[0];
      assign last  = (hits[wr_addr] == HW'(FLT_PULSES - 1));
      assign do_wr = wr_en && (!sel || last);
      always_ff @(posedge clk) begin
        if (rst || erase) begin
          for (int i = 0; i < DEPTH; i++) hits[i] <= '0;
        end else if (wr_en && sel) begin
          hits[wr_addr] <= last ? '0 : hits[wr_addr] + 1'b1;
        end
      end
    end else begin : g_plain
      logic unused_flt;
      assign unused_flt = flt_en;
      assign do_wr      = wr_en;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (do_wr) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int PULSE_MIN  = 9500,
  parameter int FLT_PULSES = 3,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prg_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  input  logic              erase,
  input  logic              flt_en,
  output logic [WORD_W-1:0] dout,
  output logic              dout_oe
);
  otp_mode_e         mode;
  logic              commit;
  logic [AW-1:0]     c_addr;
  logic [WORD_W-1:0] c_data;
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] word;
  logic              drive;

  otp_mode_dec u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .prg_n(prg_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .mode(mode)
  );

  otp_pulse_timer #(.PULSE_MIN(PULSE_MIN), .AW(AW), .DW(WORD_W)) u_tmr (
    .clk(clk), .rst(rst),
    .active(mode == M_PROGRAM),
    .hold_ok(vpp_hi && !ce_n),
    .prg_n(prg_n), .addr(addr), .din(din),
    .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  otp_array #(.DEPTH(DEPTH), .FLT_PULSES(FLT_PULSES)) u_arr (
    .clk(clk), .rst(rst), .erase(erase),
    .wr_en(commit), .wr_addr(c_addr), .wr_data(c_data),
    .flt_en(flt_en), .rd_addr(addr), .rd_data(rd_data)
  );

  always_comb begin
    drive = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_IDENT);
    if (mode == M_IDENT) word = addr[0] ? ID_DEVICE : ID_MAKER;
    else                 word = rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= drive;
      dout    <= drive ? word : '0;
    end
  end
endmodule

// File: rtl/otp_word_mem_chk.sv
module otp_word_mem_chk #(
  parameter int DEPTH      = 16,
  parameter int PULSE_MIN  = 9500,
  parameter int FLT_PULSES = 3,
  localparam int AW        = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          prg_n,
  input logic          vpp_hi,
  input logic          a9_hi,
  input logic [AW-1:0] addr,
  input logic [15:0]   din,
  input logic          erase,
  input logic          flt_en,
  input logic [15:0]   dout,
  input logic          dout_oe
);
  // R3
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_oe);

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n) |=> (!dout_oe && dout == 16'h0));

  // R4
  prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && vpp_hi && !prg_n) |=> !dout_oe);

  // R8
  id_maker_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && prg_n && !vpp_hi && a9_hi && !addr[0]) |=> (dout_oe && dout == 16'h0020));

  // R8
  id_device_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && prg_n && !vpp_hi && a9_hi && addr[0]) |=> (dout_oe && dout == 16'h008C));

  // R9
  erase_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (erase && !ce_n && !oe_n && prg_n && !a9_hi) |=> ##1 (!$past(ce_n) && !$past(oe_n) && $past(prg_n) && !$past(a9_hi) && !$past(erase))
      |-> dout == 16'hFFFF);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && prg_n) |=> dout_oe);
endmodule

bind otp_word_mem otp_word_mem_chk #(
  .DEPTH(DEPTH), .PULSE_MIN(PULSE_MIN), .FLT_PULSES(FLT_PULSES)
) u_chk (.*);

// File: tb/otp_word_mem_bench.sv
`timescale 1ns/1ps
module otp_word_mem_bench;
  localparam int DEPTH = 16;
  localparam int PMIN  = 6;
  localparam int FLT   = 3;
  localparam int AW    = $clog2(DEPTH);
  localparam int NV    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, prg_n = 1'b1;
  logic          vpp_hi = 1'b0, a9_hi = 1'b0, erase = 1'b0, flt_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic          dout_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  otp_word_mem #(.DEPTH(DEPTH), .PULSE_MIN(PMIN), .FLT_PULSES(FLT)) u_otp_word_mem (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .prg_n(prg_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .addr(addr), .din(din),
    .erase(erase), .flt_en(flt_en), .dout(dout), .dout_oe(dout_oe)
  );

  // {ce_n, oe_n, prg_n, vpp_hi, a9_hi, addr[3:0], exp_oe, exp_dout[15:0]}
  localparam logic [25:0] VEC [NV] = '{
    {5'b00100, 4'd3, 1'b1, 16'hFFFF},
    {5'b01100, 4'd3, 1'b0, 16'h0000},
    {5'b10100, 4'd3, 1'b0, 16'h0000},
    {5'b10110, 4'd3, 1'b0, 16'h0000},
    {5'b00101, 4'd2, 1'b1, 16'h0020},
    {5'b00101, 4'd5, 1'b1, 16'h008C},
    {5'b00110, 4'd4, 1'b1, 16'hFFFF},
    {5'b00000, 4'd4, 1'b0, 16'h0000}
  };

  function automatic string vlbl(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R8";
      6: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic e_oe, input logic [15:0] e_d);
    total++;
    if (dout_oe !== e_oe || dout !== e_d) begin
      bad++;
      $display("FAIL %s: got oe=%0b dout=%h, expected oe=%0b dout=%h", req, dout_oe, dout, e_oe, e_d);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic vpp, input string req,
                    input logic [15:0] e_d);
    ce_n = 0; oe_n = 0; prg_n = 1; vpp_hi = vpp; a9_hi = 0; addr = a;
    @(negedge clk);
    check(req, 1'b1, e_d);
    ce_n = 1; vpp_hi = 0;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d, input int n);
    ce_n = 0; oe_n = 1; vpp_hi = 1; a9_hi = 0; addr = a; din = d; prg_n = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R4", 1'b0, 16'h0000);
    end
    prg_n = 1;
    @(negedge clk);
    vpp_hi = 0; ce_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11 reset state
    check("R11", 1'b0, 16'h0000);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {ce_n, oe_n, prg_n, vpp_hi, a9_hi} = VEC[i][25:21];
      addr = VEC[i][20:17];
      @(negedge clk);
      check(vlbl(i), VEC[i][16], VEC[i][15:0]);
    end
    ce_n = 1; oe_n = 1; prg_n = 1; vpp_hi = 0; a9_hi = 0;
    @(negedge clk);

    // R4 commit with minimum pulse
    prog(4'd5, 16'hA5F0, PMIN);
    rd(4'd5, 1'b0, "R4", 16'hA5F0);
    // R5 AND with old word
    prog(4'd5, 16'h0FFF, PMIN);
    rd(4'd5, 1'b0, "R5", 16'h05F0);
    // R6 short pulse ignored
    prog(4'd6, 16'h1234, PMIN - 1);
    rd(4'd6, 1'b0, "R6", 16'hFFFF);
    // R3 inhibit: chip select high during strobe pulse
    ce_n = 1; oe_n = 1; vpp_hi = 1; addr = 4'd9; din = 16'h0000; prg_n = 0;
    repeat (PMIN + 2) @(negedge clk);
    prg_n = 1; @(negedge clk); vpp_hi = 0; @(negedge clk);
    rd(4'd9, 1'b0, "R3", 16'hFFFF);
    // R7 verify returns stored word
    rd(4'd5, 1'b1, "R7", 16'h05F0);
    // R8 identifier hides programmed array
    ce_n = 0; oe_n = 0; prg_n = 1; a9_hi = 1; addr = 4'd5;
    @(negedge clk);
    check("R8", 1'b1, 16'h008C);
    a9_hi = 0; ce_n = 1;
    // R10 fault injection on odd address
    flt_en = 1;
    prog(4'd7, 16'h00FF, PMIN);
    rd(4'd7, 1'b0, "R10", 16'hFFFF);
    prog(4'd7, 16'h00FF, PMIN);
    rd(4'd7, 1'b0, "R10", 16'hFFFF);
    prog(4'd7, 16'h00FF, PMIN);
    rd(4'd7, 1'b0, "R10", 16'h00FF);
    prog(4'd8, 16'h1111, PMIN);
    rd(4'd8, 1'b0, "R10", 16'h1111);
    flt_en = 0;
    // R9 erase restores ones
    erase = 1; @(negedge clk); erase = 0;
    rd(4'd5, 1'b0, "R9", 16'hFFFF);
    rd(4'd8, 1'b0, "R9", 16'hFFFF);
    rd(4'd7, 1'b0, "R9", 16'hFFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule